// File: doc/BRIEF.md
# GPIO Port Controller with Pin Interrupts

This block controls a small port of general-purpose pins (six by default) through a bank of 32-bit registers. Software reaches the registers over a simple bus: one write strobe, a byte address and write data. Read data is a combinational function of the address. For each pin, software chooses the direction, an output value and a two-bit pad setting. The pad setting becomes pull-up and Schmitt-trigger enables. Output bits can be loaded whole, or changed one at a time through write-one-to-set and write-one-to-clear ports, so no read-modify-write is needed.

Every pin input passes through a two-flop synchroniser. It then reaches a per-pin trigger detector that works in one of five modes: rising edge, falling edge, both edges, high level or low level. A match sets a raw flag. Raw flags stay set until software writes a one to the clear register. The enable mask selects which flags reach the single interrupt output.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 output value, 0x04 direction, 0x08 pad setting, 0x0C sense, 0x10 both-edge, 0x14 polarity, 0x18 enable, 0x1C raw flags, 0x20 flag clear, 0x24 bit set and 0x28 bit clear. All of them are zero after reset. The flag-clear, bit-set and bit-clear offsets, and any unmapped offset, read as zero, and writes to unmapped offsets change nothing.
- R2: A direction bit of 1 makes the pin an output, which drives `pin_oe`. A read of offset 0x00 returns the output latch for output pins and the synchronised pin level for input pins. A pin change shows up in that read after the second clock edge.
- R3: A write to offset 0x00 loads the output latch, and `pin_out` shows the latch value.
- R4: Writing 1 to a bit at offset 0x24 sets that latch bit. A 0 leaves the bit unchanged.
- R5: Writing 1 to a bit at offset 0x28 clears that latch bit. A 0 leaves the bit unchanged.
- R6: Pin i takes pad bits [2i+1:2i]. The value 00 gives pull-up with Schmitt trigger. The value 10 gives no pull with Schmitt trigger. The value 11 gives no pull and no Schmitt trigger. The value 01 acts like 00.
- R7: With sense bit 0 (edge) and both-edge bit 0, a polarity bit of 0 flags rising edges and a polarity bit of 1 flags falling edges. The flag is set at the third clock edge that samples the new pin level.
- R8: With sense bit 0 and both-edge bit 1, both edges set the flag whatever the polarity bit says.
- R9: With sense bit 1 (level), the flag is set on every cycle that the pin sits at the level the polarity bit picks: 0 for high, 1 for low. It is set again right after a clear if the level still holds.
- R10: Writing 1 to a bit at offset 0x20 clears that raw flag, and a 0 leaves it unchanged. A trigger in the same cycle as a clear wins.
- R11: Raw flags are set whatever the enable bits say. `irq` is the OR over pins of flag AND enable.
- R12: Offset 0x1C is read-only. Writes to it do not change the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | N_PINS | Raw pin levels from the pads |
| pin_out | output | N_PINS | Output latch driven to the pads |
| pin_oe | output | N_PINS | Output enable per pin |
| pad_pull_up | output | N_PINS | Pull-up enable per pin |
| pad_schmitt_en | output | N_PINS | Schmitt-trigger enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the race between a clear write and a trigger in the same cycle. It holds a level trigger across a clear: a design that lets the clear win would drop a flag that software must see again. It measures the edge-to-flag latency in both-edge mode with the polarity set to falling. A detector that is one stage short or long, or that still obeys polarity, flags on the wrong cycle or not at all. It also writes zeros to the set, clear and flag-clear ports, which must leave state untouched, and uses the reserved pad code 01 to catch a decoder that treats only 00 as pull-up.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFS_OUTVAL = 8'h00;
    localparam logic [BUS_AW-1:0] OFS_DIR    = 8'h04;
    localparam logic [BUS_AW-1:0] OFS_PAD    = 8'h08;
    localparam logic [BUS_AW-1:0] OFS_SENSE  = 8'h0C;
    localparam logic [BUS_AW-1:0] OFS_BOTH   = 8'h10;
    localparam logic [BUS_AW-1:0] OFS_POL    = 8'h14;
    localparam logic [BUS_AW-1:0] OFS_IEN    = 8'h18;
    localparam logic [BUS_AW-1:0] OFS_RAW    = 8'h1C;
    localparam logic [BUS_AW-1:0] OFS_ICLR   = 8'h20;
    localparam logic [BUS_AW-1:0] OFS_SET    = 8'h24;
    localparam logic [BUS_AW-1:0] OFS_CLR    = 8'h28;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_OUTVAL, SEL_DIR, SEL_PAD, SEL_SENSE, SEL_BOTH,
        SEL_POL, SEL_IEN, SEL_RAW, SEL_ICLR, SEL_SET, SEL_CLR
    } reg_sel_e;

    typedef enum logic [1:0] {
        PAD_PULLUP = 2'b00,
        PAD_RSVD   = 2'b01,
        PAD_FLOAT  = 2'b10,
        PAD_BARE   = 2'b11
    } pad_mode_e;

    typedef enum logic [2:0] {
        TM_RISE, TM_FALL, TM_BOTH, TM_HIGH, TM_LOW
    } trig_mode_e;

    function automatic reg_sel_e decode_ofs(input logic [BUS_AW-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFS_OUTVAL: s = SEL_OUTVAL;
            OFS_DIR:    s = SEL_DIR;
            OFS_PAD:    s = SEL_PAD;
            OFS_SENSE:  s = SEL_SENSE;
            OFS_BOTH:   s = SEL_BOTH;
            OFS_POL:    s = SEL_POL;
            OFS_IEN:    s = SEL_IEN;
            OFS_RAW:    s = SEL_RAW;
            OFS_ICLR:   s = SEL_ICLR;
            OFS_SET:    s = SEL_SET;
            OFS_CLR:    s = SEL_CLR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    // stage_q[STAGES-1] is the synchronised level, stage_q[STAGES] its previous value
    logic [W-1:0] stage_q [0:STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k <= STAGES; k++) begin
                stage_q[k] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k <= STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign lvl      = stage_q[STAGES-1];
    assign lvl_prev = stage_q[STAGES];
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic sense_level,
    input  logic both_edges,
    input  logic pol_low,
    input  logic clr,
    output logic trig,
    output logic flag
);
    trig_mode_e mode;
    logic       rise;
    logic       fall;

    assign rise = lvl & ~lvl_prev;
    assign fall = ~lvl & lvl_prev;

    // both-edge override sits above polarity, but only in edge sense
    always_comb begin
        if (sense_level)     mode = pol_low ? TM_LOW : TM_HIGH;
        else if (both_edges) mode = TM_BOTH;
        else                 mode = pol_low ? TM_FALL : TM_RISE;
    end

    always_comb begin
        unique case (mode)
            TM_RISE: trig = rise;
            TM_FALL: trig = fall;
            TM_BOTH: trig = rise | fall;
            TM_HIGH: trig = lvl;
            TM_LOW:  trig = ~lvl;
            default: trig = 1'b0;
        endcase
    end

    // a trigger in the same cycle as a clear keeps the flag set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= trig | (flag & ~clr);
    end
endmodule

// File: rtl/gpio_pad_map.sv
module gpio_pad_map
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 6
) (
    input  logic [2*N_PINS-1:0] cfg,
    output logic [N_PINS-1:0]   pull_up,
    output logic [N_PINS-1:0]   schmitt_en
);
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pad_mode_e m;
        assign m             = pad_mode_e'(cfg[2*i +: 2]);
        assign pull_up[i]    = (m == PAD_PULLUP) || (m == PAD_RSVD);
        assign schmitt_en[i] = (m != PAD_BARE);
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int N_PINS      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pad_pull_up,
    output logic [N_PINS-1:0] pad_schmitt_en,
    output logic              irq
);
    localparam int CFG_W = 2 * N_PINS;

    reg_sel_e          sel;
    logic [N_PINS-1:0] wbits;
    logic [N_PINS-1:0] outval_q, dir_q, sense_q, both_q, pol_q, ien_q;
    logic [CFG_W-1:0]  pad_q;
    logic [N_PINS-1:0] lvl, lvl_prev;
    logic [N_PINS-1:0] clr_vec, trig_vec, ris_q;
    logic [N_PINS-1:0] pin_view;
    logic              unused_wdata;

    assign sel          = decode_ofs(bus_addr);
    assign wbits        = bus_wdata[N_PINS-1:0];
    assign unused_wdata = ^bus_wdata;

    // configuration and output latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outval_q <= '0;
            dir_q    <= '0;
            pad_q    <= '0;
            sense_q  <= '0;
            both_q   <= '0;
            pol_q    <= '0;
            ien_q    <= '0;
        end else if (bus_we) begin
            unique case (sel)
                SEL_OUTVAL: outval_q <= wbits;
                SEL_SET:    outval_q <= outval_q | wbits;
                SEL_CLR:    outval_q <= outval_q & ~wbits;
                SEL_DIR:    dir_q    <= wbits;
                SEL_PAD:    pad_q    <= bus_wdata[CFG_W-1:0];
                SEL_SENSE:  sense_q  <= wbits;
                SEL_BOTH:   both_q   <= wbits;
                SEL_POL:    pol_q    <= wbits;
                SEL_IEN:    ien_q    <= wbits;
                default:    ;
            endcase
        end
    end

    assign clr_vec = (bus_we && sel == SEL_ICLR) ? wbits : '0;

    gpio_in_sync #(
        .W      (N_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .d        (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_irq
        gpio_pin_irq u_det (
            .clk         (clk),
            .rst_n       (rst_n),
            .lvl         (lvl[i]),
            .lvl_prev    (lvl_prev[i]),
            .sense_level (sense_q[i]),
            .both_edges  (both_q[i]),
            .pol_low     (pol_q[i]),
            .clr         (clr_vec[i]),
            .trig        (trig_vec[i]),
            .flag        (ris_q[i])
        );
    end

    gpio_pad_map #(
        .N_PINS (N_PINS)
    ) u_pad (
        .cfg        (pad_q),
        .pull_up    (pad_pull_up),
        .schmitt_en (pad_schmitt_en)
    );

    assign pin_view = (dir_q & outval_q) | (~dir_q & lvl);

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_OUTVAL: bus_rdata[N_PINS-1:0] = pin_view;
            SEL_DIR:    bus_rdata[N_PINS-1:0] = dir_q;
            SEL_PAD:    bus_rdata[CFG_W-1:0]  = pad_q;
            SEL_SENSE:  bus_rdata[N_PINS-1:0] = sense_q;
            SEL_BOTH:   bus_rdata[N_PINS-1:0] = both_q;
            SEL_POL:    bus_rdata[N_PINS-1:0] = pol_q;
            SEL_IEN:    bus_rdata[N_PINS-1:0] = ien_q;
            SEL_RAW:    bus_rdata[N_PINS-1:0] = ris_q;
            default:    ;
        endcase
    end

    assign pin_out = outval_q;
    assign pin_oe  = dir_q;
    assign irq     = |(ris_q & ien_q);
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_port_pkg::*;
#(
    parameter int N_PINS = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic [N_PINS-1:0] pin_out,
    input logic [N_PINS-1:0] pin_oe,
    input logic              irq,
    input logic [N_PINS-1:0] ris_q,
    input logic [N_PINS-1:0] trig_vec
);
    assert_bit_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SET) |=>
        ((pin_out & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

    assert_bit_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLR) |=>
        ((pin_out & $past(bus_wdata[N_PINS-1:0])) == '0));

    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_DIR) |=> $stable(pin_oe));

    assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ris_q & ~$past(ris_q) & ~$past(trig_vec)) == '0));

    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ICLR) |=>
        ((ris_q & $past(bus_wdata[N_PINS-1:0]) & ~$past(trig_vec)) == '0));

    assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ris_q == '0) |-> !irq);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.N_PINS(N_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .ris_q     (ris_q),
    .trig_vec  (trig_vec)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
    import gpio_port_pkg::*;

    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe, pad_pull_up, pad_schmitt_en;
    logic         irq;

    gpio_port_ctrl #(.N_PINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pad_pull_up(pad_pull_up),
        .pad_schmitt_en(pad_schmitt_en), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // reference state built from the requirements
    logic [N-1:0]   m_out = '0, m_dir = '0, m_sen = '0, m_both = '0;
    logic [N-1:0]   m_pol = '0, m_ien = '0, m_ris = '0;
    logic [2*N-1:0] m_pad = '0;
    logic [N-1:0]   s1 = '0, s2 = '0, s3 = '0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 0;

    function automatic logic [N-1:0] m_trig();
        logic [N-1:0] t;
        for (int i = 0; i < N; i++) begin
            logic r, f;
            r = s2[i] & ~s3[i];
            f = ~s2[i] & s3[i];
            if (m_sen[i])       t[i] = m_pol[i] ? ~s2[i] : s2[i];
            else if (m_both[i]) t[i] = r | f;
            else                t[i] = m_pol[i] ? f : r;
        end
        return t;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            OFS_OUTVAL: v[N-1:0]   = (m_dir & m_out) | (~m_dir & s2);
            OFS_DIR:    v[N-1:0]   = m_dir;
            OFS_PAD:    v[2*N-1:0] = m_pad;
            OFS_SENSE:  v[N-1:0]   = m_sen;
            OFS_BOTH:   v[N-1:0]   = m_both;
            OFS_POL:    v[N-1:0]   = m_pol;
            OFS_IEN:    v[N-1:0]   = m_ien;
            OFS_RAW:    v[N-1:0]   = m_ris;
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            OFS_OUTVAL: return "R2 R3 data read";
            OFS_DIR:    return "R2 direction read";
            OFS_PAD:    return "R6 pad read";
            OFS_RAW:    return "R7 R8 R9 R10 R12 flag read";
            default:    return "R1 register read";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] m_pull();
        logic [N-1:0] p;
        for (int i = 0; i < N; i++) p[i] = ~m_pad[2*i+1];
        return p;
    endfunction

    function automatic logic [N-1:0] m_smt();
        logic [N-1:0] p;
        for (int i = 0; i < N; i++) p[i] = ~(m_pad[2*i+1] & m_pad[2*i]);
        return p;
    endfunction

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] wd,
                        input logic [N-1:0] pins);
        logic [N-1:0] clr;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; pin_in = pins;
        #1;
        if (!we) chk(tag_of(a), bus_rdata, m_read(a));
        chk("R3 pin_out", 32'(pin_out), 32'(m_out));
        chk("R2 pin_oe", 32'(pin_oe), 32'(m_dir));
        chk("R6 pull", 32'(pad_pull_up), 32'(m_pull()));
        chk("R6 schmitt", 32'(pad_schmitt_en), 32'(m_smt()));
        chk("R11 irq", 32'(irq), 32'(|(m_ris & m_ien)));
        @(posedge clk);
        clr   = (we && a == OFS_ICLR) ? wd[N-1:0] : '0;
        m_ris = m_trig() | (m_ris & ~clr);
        s3 = s2; s2 = s1; s1 = pins;
        if (we) begin
            case (a)
                OFS_OUTVAL: m_out  = wd[N-1:0];
                OFS_SET:    m_out  = m_out | wd[N-1:0];
                OFS_CLR:    m_out  = m_out & ~wd[N-1:0];
                OFS_DIR:    m_dir  = wd[N-1:0];
                OFS_PAD:    m_pad  = wd[2*N-1:0];
                OFS_SENSE:  m_sen  = wd[N-1:0];
                OFS_BOTH:   m_both = wd[N-1:0];
                OFS_POL:    m_pol  = wd[N-1:0];
                OFS_IEN:    m_ien  = wd[N-1:0];
                default:    ;
            endcase
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pins;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every offset reads zero after reset
        for (int k = 0; k < 12; k++) step(1'b0, 8'(k * 4), 32'h0, '0);
        for (int k = 0; k < 12; k++) begin
            bus_addr = 8'(k * 4);
            #1 chk("R1 reset value", bus_rdata, 32'h0);
        end

        // R4 / R5: bit set and bit clear ports
        step(1'b1, OFS_DIR, 32'h3F, '0);
        step(1'b1, OFS_OUTVAL, 32'h15, '0);
        step(1'b1, OFS_SET, 32'h22, '0);
        #1 chk("R4 set ones", 32'(pin_out), 32'h37);
        step(1'b1, OFS_SET, 32'h0, '0);
        #1 chk("R4 set zero no effect", 32'(pin_out), 32'h37);
        step(1'b1, OFS_CLR, 32'h05, '0);
        #1 chk("R5 clear ones", 32'(pin_out), 32'h32);
        step(1'b1, OFS_CLR, 32'h0, '0);
        #1 chk("R5 clear zero no effect", 32'(pin_out), 32'h32);

        // R6: pad codes 00,01,10,11 on pins 0..3
        step(1'b1, OFS_PAD, 32'h0E4, '0);
        #1 chk("R6 pull codes", 32'(pad_pull_up), 32'h33);
        chk("R6 schmitt codes", 32'(pad_schmitt_en), 32'h37);

        // R9 / R10: level trigger beats a clear
        step(1'b1, OFS_SENSE, 32'h1, 6'h01);
        repeat (3) step(1'b0, OFS_RAW, 32'h0, 6'h01);
        step(1'b1, OFS_ICLR, 32'h3F, 6'h01);
        step(1'b0, OFS_RAW, 32'h0, 6'h01);
        chk("R9 R10 level re-set after clear", bus_rdata, 32'h1);
        step(1'b1, OFS_RAW, 32'h0, 6'h01);
        #1 chk("R12 raw flags read-only", {31'h0, bus_rdata[0]}, 32'h1);
        step(1'b1, OFS_SENSE, 32'h0, 6'h01);
        step(1'b1, OFS_ICLR, 32'h0, 6'h01);
        #1 chk("R10 zero clear no effect", bus_rdata, 32'h0);
        bus_addr = OFS_RAW;
        #1 chk("R10 zero clear keeps flag", bus_rdata, 32'h1);
        step(1'b1, OFS_ICLR, 32'h1, 6'h01);
        step(1'b0, OFS_RAW, 32'h0, 6'h01);
        chk("R10 edge flag cleared", bus_rdata, 32'h0);

        // R8: both edges override falling polarity, and R7 latency
        step(1'b1, OFS_BOTH, 32'h1, 6'h01);
        step(1'b1, OFS_POL, 32'h1, 6'h01);
        repeat (4) step(1'b0, OFS_RAW, 32'h0, 6'h00);
        step(1'b1, OFS_ICLR, 32'h1, 6'h00);
        step(1'b0, OFS_RAW, 32'h0, 6'h01);
        step(1'b0, OFS_RAW, 32'h0, 6'h01);
        #1 chk("R7 R8 flag not yet set", {31'h0, bus_rdata[0]}, 32'h0);
        step(1'b0, OFS_RAW, 32'h0, 6'h01);
        #1 chk("R7 R8 rising edge under both-edge", {31'h0, bus_rdata[0]}, 32'h1);
        chk("R11 irq masked", 32'(irq), 32'h0);
        step(1'b1, OFS_IEN, 32'h1, 6'h01);
        #1 chk("R11 irq enabled", 32'(irq), 32'h1);

        // random traffic against the reference
        pins = 6'h01;
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  a;
            logic [31:0] wd;
            logic        we;
            a  = 8'(($urandom % 12) * 4);
            wd = $urandom;
            we = ($urandom % 5) < 2;
            if (($urandom % 3) == 0) pins[$urandom % N] ^= 1'b1;
            step(we, a, wd, pins);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule